// File: doc/BRIEF.md
# Memory Read Latency Monitor

This block counts read traffic toward local DRAM on three memory-controller channels so that software can work out the average read latency. Each channel brings in a one-cycle issue strobe and a one-cycle return strobe. An internal up/down tracker follows how many reads that channel currently has in flight. While counting is on, every channel counts its issued reads. In the same cycle it adds the current in-flight depth to an integrating counter. One shared counter counts the elapsed cycles.

Software reads the integral and the request count and divides the first by the second to get the mean number of cycles a read spends in flight. The cycle counter converts that figure to time. A small register port handles control and readout. It has a gate bit that lets the counters advance, a run/clear command word, sticky wrap flags and 64-bit counter reads. Reads return data one cycle after the strobe.

Top module: `lat_mon`

## Requirements
- R1: After reset, every counter, the wrap-flag word (0x810), the gate register (0x800) and the command register (0x808) read zero.
- R2: The counters advance only in cycles where gate bit 0 (0x800) and run bit 0 (0x808) are both 1. The cycle counter (0x818) adds one in each such cycle.
- R3: The request counter of channel i (at 0x820 + 0x18·i) adds one in each counting cycle in which that channel's issue strobe is high.
- R4: Each channel's in-flight depth rises by one on an issue strobe and falls by one on a return strobe, and is unchanged when both come in the same cycle. In each counting cycle, the integrating counter of channel i (at 0x830 + 0x18·i) adds the depth held before that cycle's strobes.
- R5: When counting is off, the counters hold their values while the in-flight depth keeps following the strobes. The depth is therefore correct when counting resumes.
- R6: A write to 0x808 with bit 1 set zeroes all counters and all wrap flags, but only while gate bit 0 is 1. Bit 0 of the same write becomes the new run bit.
- R7: Wrap flags are sticky. Each is set when its counter carries past all-ones and is cleared only by the clear command. The flag positions are: bit 0 for cycles; for channel i, bit 1+3i for the integral and bit 3+3i for requests. All other bits read zero.
- R8: Read data appears one cycle after the read strobe and holds until the next read. An address outside the map returns zero.
- R9: Writes to the wrap-flag address or to any counter address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after the read strobe |
| rd_issue | input | 3 | Per-channel read-issued strobe |
| rd_return | input | 3 | Per-channel read-returned strobe |

## Verification
The assertions check the following on every cycle: counters stay frozen while counting is off, a set wrap flag stays set until a clear, a clear leaves zero behind, the in-flight depth is unchanged under a same-cycle issue and return, the cycle counter steps by exactly one while running, and read data holds between reads. Only the bench scenarios can show that the integral equals the sum of the depths over a stream of mixed strobes, that a clear is refused while the gate is off, and that the depth built up while stopped feeds the integral after a restart. They also show that every wrap flag lands at its stated bit and that writes to read-only addresses leave no trace.

// File: rtl/lat_mon_pkg.sv
package lat_mon_pkg;
    localparam int NCH    = 3;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_GATE = 12'h800;
    localparam logic [ADDR_W-1:0] A_CMD  = 12'h808;
    localparam logic [ADDR_W-1:0] A_FLAG = 12'h810;
    localparam logic [ADDR_W-1:0] A_CYC  = 12'h818;
    localparam int CH_REQ_BASE = 'h820;
    localparam int CH_ACC_BASE = 'h830;
    localparam int CH_STRIDE   = 'h18;

    localparam int FLAG_CYC = 0;

    function automatic int flag_acc(input int ch);
        return 1 + 3 * ch;
    endfunction

    function automatic int flag_req(input int ch);
        return 3 + 3 * ch;
    endfunction

    typedef struct packed {
        logic              gate;
        logic              run;
        logic [DATA_W-1:0] rdata;
    } ctl_t;
endpackage

// File: rtl/lat_mon_ctr.sv
module lat_mon_ctr #(
    parameter int W  = 64,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clr,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  value,
    output logic          ovf
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } st_t;

    st_t        st_d, st_q;
    logic [W:0] sum;

    always_comb begin
        sum  = {1'b0, st_q.cnt} + {{(W + 1 - IW){1'b0}}, inc};
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            st_d.cnt = sum[W-1:0];
            if (sum[W]) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.cnt;
    assign ovf   = st_q.ovf;

    // R5: a stopped counter holds
    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(value));
    // R7: wrap flag is sticky until a clear
    p_sticky_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);
    // R6: clear leaves zero behind
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0 && !ovf));
endmodule

// File: rtl/lat_mon_chan.sv
module lat_mon_chan #(
    parameter int CNT_W    = 64,
    parameter int FLIGHT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             issue,
    input  logic             ret,
    output logic [CNT_W-1:0] req_cnt,
    output logic             req_ovf,
    output logic [CNT_W-1:0] acc_cnt,
    output logic             acc_ovf
);
    logic [FLIGHT_W-1:0] flight_d, flight_q;

    always_comb begin
        flight_d = flight_q;
        case ({issue, ret})
            2'b10:   flight_d = flight_q + 1'b1;
            2'b01:   flight_d = flight_q - 1'b1;
            default: flight_d = flight_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flight_q <= '0;
        else        flight_q <= flight_d;
    end

    lat_mon_ctr #(.W(CNT_W), .IW(1)) u_req (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr),
        .inc(issue), .value(req_cnt), .ovf(req_ovf)
    );

    lat_mon_ctr #(.W(CNT_W), .IW(FLIGHT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr),
        .inc(flight_q), .value(acc_cnt), .ovf(acc_ovf)
    );

    // R4: same-cycle issue and return leave the depth unchanged
    p_flight_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ret) |=> $stable(flight_q));
    // R4: a return never arrives with nothing in flight
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !issue) |-> (flight_q != '0));
endmodule

// File: rtl/lat_mon.sv
module lat_mon
    import lat_mon_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int FLIGHT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [11:0]       reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic [2:0]        rd_issue,
    input  logic [2:0]        rd_return
);
    ctl_t ctl_d, ctl_q;

    logic             count_en, clear_cmd;
    logic [CNT_W-1:0] cyc_cnt;
    logic             cyc_ovf;
    logic [CNT_W-1:0] req_cnt [NCH];
    logic [CNT_W-1:0] acc_cnt [NCH];
    logic [NCH-1:0]   req_ovf, acc_ovf;
    logic [DATA_W-1:0] flags;

    function automatic logic [DATA_W-1:0] widen(input logic [CNT_W-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[CNT_W-1:0] = v;
        return r;
    endfunction

    assign count_en  = ctl_q.gate && ctl_q.run;
    assign clear_cmd = reg_wr_en && (reg_addr == A_CMD) && reg_wdata[1] && ctl_q.gate;

    lat_mon_ctr #(.W(CNT_W), .IW(1)) u_cyc (
        .clk(clk), .rst_n(rst_n), .en(count_en), .clr(clear_cmd),
        .inc(1'b1), .value(cyc_cnt), .ovf(cyc_ovf)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        lat_mon_chan #(.CNT_W(CNT_W), .FLIGHT_W(FLIGHT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(count_en), .clr(clear_cmd),
            .issue(rd_issue[g]), .ret(rd_return[g]),
            .req_cnt(req_cnt[g]), .req_ovf(req_ovf[g]),
            .acc_cnt(acc_cnt[g]), .acc_ovf(acc_ovf[g])
        );
    end

    always_comb begin
        flags = '0;
        flags[FLAG_CYC] = cyc_ovf;
        for (int i = 0; i < NCH; i++) begin
            flags[flag_acc(i)] = acc_ovf[i];
            flags[flag_req(i)] = req_ovf[i];
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr_en && reg_addr == A_GATE) ctl_d.gate = reg_wdata[0];
        if (reg_wr_en && reg_addr == A_CMD)  ctl_d.run  = reg_wdata[0];
        if (reg_rd_en) begin
            ctl_d.rdata = '0;
            if (reg_addr == A_GATE) ctl_d.rdata[0] = ctl_q.gate;
            if (reg_addr == A_CMD)  ctl_d.rdata[0] = ctl_q.run;
            if (reg_addr == A_FLAG) ctl_d.rdata    = flags;
            if (reg_addr == A_CYC)  ctl_d.rdata    = widen(cyc_cnt);
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr == ADDR_W'(CH_REQ_BASE + CH_STRIDE * i)) ctl_d.rdata = widen(req_cnt[i]);
                if (reg_addr == ADDR_W'(CH_ACC_BASE + CH_STRIDE * i)) ctl_d.rdata = widen(acc_cnt[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign reg_rdata = ctl_q.rdata;

    // R2: the cycle counter steps by exactly one while counting
    p_cycle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !clear_cmd) |=> (cyc_cnt == CNT_W'($past(cyc_cnt) + 1'b1)));
    // R2: the cycle counter is frozen when the gate or run bit is off
    p_cycle_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clear_cmd) |=> $stable(cyc_cnt));
    // R8: read data holds between reads
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata));
endmodule

// File: tb/lat_mon_bench.sv
module lat_mon_bench;
    localparam int BW   = 8;
    localparam int WRAP = 1 << BW;
    localparam logic [11:0] GATE = 12'h800, CMD = 12'h808, FLG = 12'h810, CYC = 12'h818;

    // {issue[2:0], return[2:0]} per cycle, bit index = channel
    localparam logic [5:0] VEC [12] = '{
        6'b111_000, 6'b011_000, 6'b001_000, 6'b000_000,
        6'b100_001, 6'b000_110, 6'b001_001, 6'b000_011,
        6'b010_000, 6'b000_111, 6'b101_000, 6'b000_101
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [2:0]  iss = '0, ret = '0;

    int checks = 0, errors = 0, wd = 0;
    int m_req [3], m_acc [3], m_inf [3], m_cyc;
    logic [63:0] m_stat;
    bit m_gate, m_run;

    always #5 clk = ~clk;

    lat_mon #(.CNT_W(BW), .FLIGHT_W(8)) u_lat_mon (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .rd_issue(iss), .rd_return(ret)
    );

    function automatic logic [11:0] req_a(input int ch);
        return 12'(12'h820 + 24 * ch);
    endfunction
    function automatic logic [11:0] acc_a(input int ch);
        return 12'(12'h830 + 24 * ch);
    endfunction

    function automatic int wrapv(input int v, input int bitpos);
        if (v >= WRAP) m_stat[bitpos] = 1'b1;
        return v % WRAP;
    endfunction

    task automatic step(input logic [2:0] s_iss, input logic [2:0] s_ret, input bit w, input bit r,
                        input logic [11:0] a, input logic [63:0] d);
        iss = s_iss; ret = s_ret; wr_en = w; rd_en = r; addr = a; wdata = d;
        @(posedge clk);
        if (m_gate && m_run) begin
            m_cyc = wrapv(m_cyc + 1, 0);
            for (int i = 0; i < 3; i++) begin
                m_req[i] = wrapv(m_req[i] + int'(s_iss[i]), 3 + 3 * i);
                m_acc[i] = wrapv(m_acc[i] + m_inf[i], 1 + 3 * i);
            end
        end
        for (int i = 0; i < 3; i++) m_inf[i] = m_inf[i] + int'(s_iss[i]) - int'(s_ret[i]);
        if (w && a == CMD) begin
            if (d[1] && m_gate) begin
                m_cyc = 0; m_stat = '0;
                for (int i = 0; i < 3; i++) begin m_req[i] = 0; m_acc[i] = 0; end
            end
            m_run = d[0];
        end
        if (w && a == GATE) m_gate = d[0];
        @(negedge clk);
        iss = '0; ret = '0; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(3'b000, 3'b000, 1'b0, 1'b0, 12'h0, 64'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        step(3'b000, 3'b000, 1'b1, 1'b0, a, d);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [63:0] exp);
        step(3'b000, 3'b000, 1'b0, 1'b1, a, 64'h0);
        check(tag, rdata, exp);
    endtask

    task automatic rd_all(input string tag);
        rd_chk({tag, " R2 cycles"}, CYC, 64'(m_cyc));
        for (int i = 0; i < 3; i++) begin
            rd_chk({tag, " R3 requests"}, req_a(i), 64'(m_req[i]));
            rd_chk({tag, " R4 integral"}, acc_a(i), 64'(m_acc[i]));
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", wd);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_cyc = 0; m_stat = '0; m_gate = 0; m_run = 0;
        for (int i = 0; i < 3; i++) begin m_req[i] = 0; m_acc[i] = 0; m_inf[i] = 0; end
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_chk("R1 cycles", CYC, 64'h0);
        rd_chk("R1 flags", FLG, 64'h0);
        rd_chk("R1 gate", GATE, 64'h0);
        rd_chk("R1 command", CMD, 64'h0);
        rd_chk("R1 requests ch0", req_a(0), 64'h0);

        // R2: run without the gate counts nothing
        wr(CMD, 64'h1);
        idle(5);
        rd_chk("R2 no gate", CYC, 64'h0);
        rd_chk("R2 run bit readback", CMD, 64'h1);
        wr(CMD, 64'h0);

        // table-driven traffic (R3, R4)
        wr(GATE, 64'h1);
        wr(CMD, 64'h1);
        for (int k = 0; k < 12; k++) step(VEC[k][5:3], VEC[k][2:0], 1'b0, 1'b0, 12'h0, 64'h0);
        wr(CMD, 64'h0);
        rd_chk("R2 cycles counted", CYC, 64'd13);
        rd_all("table");

        // R5: stopped counters hold; depth keeps tracking
        step(3'b001, 3'b000, 1'b0, 1'b0, 12'h0, 64'h0);
        step(3'b001, 3'b000, 1'b0, 1'b0, 12'h0, 64'h0);
        rd_chk("R5 requests held", req_a(0), 64'(m_req[0]));
        rd_chk("R5 cycles held", CYC, 64'd13);
        wr(CMD, 64'h1);
        idle(3);
        step(3'b000, 3'b001, 1'b0, 1'b0, 12'h0, 64'h0);
        step(3'b000, 3'b001, 1'b0, 1'b0, 12'h0, 64'h0);
        wr(CMD, 64'h0);
        rd_chk("R5 integral after restart", acc_a(0), 64'(m_acc[0]));

        // R6: clear refused with the gate off, accepted with it on
        wr(GATE, 64'h0);
        wr(CMD, 64'h2);
        wr(GATE, 64'h1);
        rd_chk("R6 clear refused", CYC, 64'(m_cyc));
        wr(CMD, 64'h2);
        rd_chk("R6 cleared cycles", CYC, 64'h0);
        rd_chk("R6 cleared integral", acc_a(0), 64'h0);

        // R7: wrap flags
        wr(CMD, 64'h1);
        for (int k = 0; k < 4; k++) step(3'b010, 3'b000, 1'b0, 1'b0, 12'h0, 64'h0);
        for (int k = 0; k < 300; k++) step(3'b100, 3'b100, 1'b0, 1'b0, 12'h0, 64'h0);
        for (int k = 0; k < 4; k++) step(3'b000, 3'b010, 1'b0, 1'b0, 12'h0, 64'h0);
        wr(CMD, 64'h0);
        rd_chk("R7 flag positions", FLG, 64'h211);
        rd_chk("R4 same-cycle integral ch2", acc_a(2), 64'h0);
        rd_all("wrap");
        idle(5);
        rd_chk("R7 flags sticky", FLG, 64'h211);

        // R9: writes to read-only addresses ignored
        wr(FLG, 64'h0);
        rd_chk("R9 flag write ignored", FLG, 64'h211);
        wr(CYC, 64'h5A);
        rd_chk("R9 counter write ignored", CYC, 64'(m_cyc));
        wr(CMD, 64'h2);
        rd_chk("R7 flags cleared", FLG, 64'h0);

        // R8: unmapped reads
        rd_chk("R8 unmapped gap", 12'h828, 64'h0);
        rd_chk("R8 unmapped far", 12'h900, 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule